// File: doc/BRIEF.md
# SAR Conversion Start Sequencer

This block is the digital control for a 14-bit successive-approximation converter. A conversion can start in two ways. The first is a rising edge on an asynchronous convert-start input, accepted only while chip-select and read are both inactive (high). The second is a falling edge of chip-select while convert-start is held low. On a start, the block switches the track/hold into hold and pulls an active-low busy flag. It then resolves one bit per conversion clock, most significant bit first. On each clock it presents a trial word to the external DAC and reads back the comparator's decision bit.

When the last bit is decided, the block releases the hold and clears busy. In the same clock it loads the result register in two's complement form, obtained by inverting the top bit of the offset-binary search word. The result register changes only at that point, so a read during a conversion sees the previous result. The conversion clock comes from an external clock input or from an internal oscillator input, chosen by a select line.

Top module: `sar_conv_seq`

## Requirements
- R1: While cs_ni and rd_ni are high and convert-start was low, a rising conv_start_i starts a conversion. busy_no is first seen low in the third clock period after the input change, because of the two synchroniser flops and one more edge.
- R2: While conv_start_i is low, a falling cs_ni starts a conversion with the same latency as R1.
- R3: A rising conv_start_i while cs_ni or rd_ni is low starts nothing. busy_no stays high and result_o is unchanged.
- R4: A conversion keeps busy_no low for exactly 14 clocks. hold_o is 1 throughout those clocks and 0 afterwards.
- R5: In conversion step j (0..13), trial_o has bit 13-j set, the bits above it equal to the decisions already made, and the bits below it clear. A decision keeps the trial bit when cmp_i is 1 (input at or above the trial).
- R6: At the end of a conversion, result_o takes the final search word with bit 13 inverted. This is the two's complement code, for example offset code 0x2000 gives 0. result_o does not change while busy_no is low.
- R7: A start request of either kind that arrives while busy_no is low is ignored. It neither lengthens the conversion nor starts another one afterwards.
- R8: With clk_sel_i = 1 the block runs from clk_int_i. With clk_sel_i = 0 it runs from clk_ext_i.
- R9: After reset, busy_no = 1, hold_o = 0, trial_o = 0 and result_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext_i | input | 1 | External conversion clock |
| clk_int_i | input | 1 | Internal oscillator clock |
| clk_sel_i | input | 1 | 1 selects the internal oscillator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_start_i | input | 1 | Asynchronous convert-start request |
| cs_ni | input | 1 | Chip-select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial |
| trial_o | output | 14 | Trial word driven to the DAC (offset binary) |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| busy_no | output | 1 | Conversion in progress, active low |
| result_o | output | 14 | Last result, two's complement |

## Verification
A behavioural comparator drives the block from a signed input. A strided sweep over the full input range, plus the four extreme and zero-crossing codes, separates a wrong bit order, a wrong keep or clear decision, and a missing sign inversion. Successive conversions alternate between the two start modes, which shows that both paths give identical timing. Start requests with read or chip-select low, and retriggers in mid-conversion in each mode, tell gated and ignored requests apart from accepted ones. Conversions run with one clock stopped at each select setting to show which clock is in use.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_clk_mux.sv
module sar_clk_mux (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  output logic clk_o
);
  // select is expected to change only while both clocks are low
  assign clk_o = sel_i ? clk_b_i : clk_a_i;
endmodule

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] d;
    if (s == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_seq_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] word_o,
  output logic         done_o,
  output logic         active_o
);
  localparam int unsigned IDX_W = $clog2(W);

  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     sar_q, bit_mask, low_mask, kept;

  assign bit_mask = {{(W-1){1'b0}}, 1'b1} << idx_q;
  assign low_mask = (bit_mask << 1) - {{(W-1){1'b0}}, 1'b1};
  assign kept     = cmp_i ? sar_q : (sar_q & ~bit_mask);
  assign done_o   = (state_q == ST_CONV) && (idx_q == '0);
  assign active_o = (state_q == ST_CONV);
  assign trial_o  = sar_q;
  assign word_o   = kept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_CONV;
        idx_q   <= IDX_W'(W-1);
        sar_q   <= {1'b1, {(W-1){1'b0}}};
      end
    end else if (idx_q == '0) begin
      state_q <= ST_IDLE;
      sar_q   <= kept;
    end else begin
      idx_q <= idx_q - 1'b1;
      sar_q <= kept | (bit_mask >> 1);
    end
  end

  // R5: current trial bit set, all lower bits clear
  a_r5_trial_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> ((sar_q & low_mask) == bit_mask));

  // R7: once running, index only counts down; a start cannot restart it
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_CONV) && $past(state_q == ST_CONV)) |-> (idx_q == $past(idx_q) - 1'b1));

  // R4: conversion ends right after the last bit
  a_r4_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_ext_i,
  input  logic              clk_int_i,
  input  logic              clk_sel_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              hold_o,
  output logic              busy_no,
  output logic [DATA_W-1:0] result_o
);
  logic              conv_clk;
  logic [2:0]        sync_v;
  logic              s_conv, s_cs, s_rd;
  logic              conv_q, cs_q;
  logic              conv_rise, cs_fall, start_req, start_go;
  logic              done, active;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] result_q;
  logic              hold_q;

  sar_clk_mux i_clk_mux (
    .clk_a_i (clk_ext_i),
    .clk_b_i (clk_int_i),
    .sel_i   (clk_sel_i),
    .clk_o   (conv_clk)
  );

  // bit order: {rd, cs, conv}; strobes idle high, convert-start idle low
  sar_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk_i   (conv_clk),
    .rst_ni  (rst_ni),
    .async_i ({rd_ni, cs_ni, conv_start_i}),
    .sync_o  (sync_v)
  );
  assign s_conv = sync_v[0];
  assign s_cs   = sync_v[1];
  assign s_rd   = sync_v[2];

  always_ff @(posedge conv_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      conv_q <= s_conv;
      cs_q   <= s_cs;
    end
  end

  assign conv_rise = s_conv & ~conv_q;
  assign cs_fall   = ~s_cs & cs_q;
  assign start_req = (conv_rise & s_cs & s_rd) | (cs_fall & ~s_conv);
  assign start_go  = start_req & ~active;

  sar_core #(.W(DATA_W)) i_core (
    .clk_i    (conv_clk),
    .rst_ni   (rst_ni),
    .start_i  (start_req),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .word_o   (word),
    .done_o   (done),
    .active_o (active)
  );

  always_ff @(posedge conv_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      hold_q   <= 1'b0;
    end else begin
      if (start_go)  hold_q <= 1'b1;
      else if (done) hold_q <= 1'b0;
      // offset binary to two's complement
      if (done) result_q <= {~word[DATA_W-1], word[DATA_W-2:0]};
    end
  end

  assign hold_o   = hold_q;
  assign busy_no  = ~active;
  assign result_o = result_q;

  // R4: track/hold in hold whenever busy
  a_r4_hold_busy: assert property (@(posedge conv_clk) disable iff (!rst_ni)
    !busy_no |-> hold_o);

  // R6: result frozen during a conversion
  a_r6_result_frozen: assert property (@(posedge conv_clk) disable iff (!rst_ni)
    (!busy_no && $past(!busy_no)) |-> $stable(result_o));

  // R1 / R2: busy only falls after a qualified start request
  a_r1_start_cause: assert property (@(posedge conv_clk) disable iff (!rst_ni)
    $fell(busy_no) |-> $past(start_req));
endmodule

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
  logic        tb_clk = 1'b0;
  logic        ext_en, int_en;
  logic        clk_sel, rst_n, conv, cs_n, rd_n, cmp;
  logic [13:0] trial, result, code_q;
  logic        hold, busy_n;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 tb_clk = ~tb_clk;

  sar_conv_seq i_sar_conv_seq (
    .clk_ext_i    (tb_clk & ext_en),
    .clk_int_i    (tb_clk & int_en),
    .clk_sel_i    (clk_sel),
    .rst_ni       (rst_n),
    .conv_start_i (conv),
    .cs_ni        (cs_n),
    .rd_ni        (rd_n),
    .cmp_i        (cmp),
    .trial_o      (trial),
    .hold_o       (hold),
    .busy_no      (busy_n),
    .result_o     (result)
  );

  // behavioural comparator: input at or above trial
  assign cmp = (trial <= code_q);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge tb_clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle_check(input string req, input int n);
    logic [13:0] prev;
    bit ok;
    prev = result;
    ok = 1'b1;
    repeat (n) begin
      @(negedge tb_clk);
      if (!busy_n || result != prev) ok = 1'b0;
    end
    chk(ok, req, int'(busy_n), 1);
  endtask

  // one conversion; call at a negedge with the start inputs idle
  task automatic run_conv(input bit cs_mode, input int vin, input bit retrig);
    int lat, len, exp_t;
    bit trial_ok, hold_ok, res_ok;
    logic [13:0] prev_res;
    code_q   = 14'(vin + 8192);
    prev_res = result;
    if (cs_mode) cs_n = 1'b0;
    else         conv = 1'b1;
    lat = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge tb_clk);
      if (!busy_n) begin
        lat = i;
        break;
      end
    end
    chk(lat == 3, cs_mode ? "R2 start latency" : "R1 start latency", lat, 3);
    len = 0; trial_ok = 1'b1; hold_ok = 1'b1; res_ok = 1'b1;
    while (!busy_n && len < 40) begin
      if (len < 14) begin
        exp_t = (int'(code_q) & ~((1 << (14 - len)) - 1)) | (1 << (13 - len));
        if (int'(trial) != exp_t) trial_ok = 1'b0;
      end
      if (!hold) hold_ok = 1'b0;
      if (result != prev_res) res_ok = 1'b0;
      if (retrig && len == 3) begin
        if (cs_mode) cs_n = 1'b1; else conv = 1'b0;
      end
      if (retrig && len == 7) begin
        if (cs_mode) cs_n = 1'b0; else conv = 1'b1;
      end
      len++;
      @(negedge tb_clk);
    end
    chk(len == 14, "R4 busy length", len, 14);
    chk(hold_ok, "R4 hold during conversion", 0, 1);
    chk(!hold, "R4 hold released", int'(hold), 0);
    chk(trial_ok, "R5 trial sequence", vin, vin);
    chk(res_ok, "R6 result frozen while busy", int'(result), int'(prev_res));
    chk($signed(result) == vin, "R6 two's complement result", int'($signed(result)), vin);
    if (retrig) idle_check("R7 retrigger ignored", 10);
    if (cs_mode) cs_n = 1'b1;
    else         conv = 1'b0;
    repeat (4) @(negedge tb_clk);
  endtask

  initial begin
    bit mode;
    logic [13:0] saved;
    ext_en = 1'b1; int_en = 1'b1; clk_sel = 1'b0;
    rst_n = 1'b0; conv = 1'b0; cs_n = 1'b1; rd_n = 1'b1; code_q = '0;
    repeat (3) @(negedge tb_clk);
    rst_n = 1'b1;
    @(negedge tb_clk);
    chk(busy_n == 1'b1, "R9 reset busy", int'(busy_n), 1);
    chk(hold == 1'b0, "R9 reset hold", int'(hold), 0);
    chk(trial == '0, "R9 reset trial", int'(trial), 0);
    chk(result == '0, "R9 reset result", int'(result), 0);

    // boundary codes
    run_conv(1'b0, 8191, 1'b0);
    run_conv(1'b1, -8192, 1'b0);
    run_conv(1'b0, 0, 1'b0);
    run_conv(1'b1, -1, 1'b0);

    // strided sweep, alternating start modes
    mode = 1'b0;
    for (int v = -8192; v < 8192; v += 37) begin
      run_conv(mode, v, 1'b0);
      mode = ~mode;
    end

    // R7: retrigger in both modes
    run_conv(1'b0, 1234, 1'b1);
    run_conv(1'b1, -777, 1'b1);

    // R3: read low gates convert-start
    rd_n = 1'b0;
    @(negedge tb_clk);
    conv = 1'b1;
    idle_check("R3 start with rd low", 10);
    conv = 1'b0;
    repeat (4) @(negedge tb_clk);
    rd_n = 1'b1;
    repeat (4) @(negedge tb_clk);

    // R3: chip-select low gates convert-start
    code_q = 14'(555 + 8192);
    conv = 1'b1;
    for (int i = 0; i < 40 && !busy_n == 1'b0; i++) @(negedge tb_clk);
    for (int i = 0; i < 40 && !busy_n; i++) @(negedge tb_clk);
    cs_n = 1'b0;
    repeat (4) @(negedge tb_clk);
    conv = 1'b0;
    repeat (4) @(negedge tb_clk);
    saved = result;
    chk($signed(result) == 555, "R3 setup conversion", int'($signed(result)), 555);
    conv = 1'b1;
    idle_check("R3 start with cs low", 10);
    chk(result == saved, "R3 result untouched", int'(result), int'(saved));
    conv = 1'b0;
    repeat (4) @(negedge tb_clk);
    cs_n = 1'b1;
    repeat (4) @(negedge tb_clk);

    // R8: internal oscillator with external clock stopped
    clk_sel = 1'b1;
    ext_en  = 1'b0;
    run_conv(1'b0, 4321, 1'b0);
    run_conv(1'b1, -4321, 1'b0);
    chk($signed(result) == -4321, "R8 internal clock select", int'($signed(result)), -4321);
    ext_en  = 1'b1;
    clk_sel = 1'b0;
    int_en  = 1'b0;
    run_conv(1'b0, -100, 1'b0);
    chk($signed(result) == -100, "R8 external clock select", int'($signed(result)), -100);
    int_en = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule